// File: doc/BRIEF.md
# Host SPI Slave Control Port with Receive Flow Control

This block is the device-side end of a host control link over SPI. An external controller selects the port with an active-low chip select, clocks it with a serial clock that idles low, and moves bytes MSB first. Input bits are taken on the rising clock edge. Output bits change after the falling edge, while the clock is low. All three host pins are brought into the system clock domain through synchronizers, so the serial clock must be several times slower than the system clock.

The first byte of every transfer is a header. It carries a 7-bit target address and a direction bit. When the address matches the device address input, the transfer is either a write or a read. In a write, the following bytes are pushed into a receive FIFO that internal logic drains over a byte-wide show-ahead interface. In a read, bytes that internal logic queued in a transmit FIFO are shifted back to the host. A busy output with hysteresis tells the host when to pause writing. An attention output tells the host that read data is waiting.

Top module: `hostSpiPort`

## Requirements
- R1: Bits 7..1 of the header byte are the address, received address bit 6 first. Bit 0 is the direction: 1 means the host reads and 0 means the host writes. A header is acted on only when its address equals `devAddr`.
- R2: In a write transfer, every complete byte after the header enters the receive FIFO in arrival order. Each byte is assembled MSB first from `mosi` values taken at `sclk` rising edges. The bytes leave in the same order on `rxData` / `rxValid` / `rxPop`.
- R3: After a header whose address does not match, nothing is stored and `misoOe` stays low until chip select is released.
- R4: In a read transfer, queued transmit bytes are sent MSB first, with `miso` updated only after `sclk` falling edges. A byte is removed from the transmit FIFO only once the host has clocked in its first bit. Trailing clock edges at the end of a transfer therefore never lose a byte.
- R5: A read byte slot that finds the transmit FIFO empty sends 0x00.
- R6: `misoOe` is high only during the data phase of a matched read. It is low before the header completes and after chip select is released, which is the high-impedance state.
- R7: With the default 16-entry receive FIFO, `busy` rises when at most one entry is free (15 or 16 held). It falls only once at least four entries are free (12 or fewer held).
- R8: Accepting a byte into the transmit FIFO sets `irq`. While deselected this happens right away; while selected it waits for the next `sclk` falling edge. `irq` is cleared when chip select is released.
- R9: Releasing chip select part-way through a byte discards the partial byte, and the next transfer starts with a fresh header.
- R10: A write byte that arrives when the receive FIFO is full is dropped, and the stored contents stay unchanged.
- R11: After reset, `busy`, `irq`, `misoOe`, `miso` and `rxValid` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| devAddr | input | 7 | Address this port answers to |
| sclk | input | 1 | Host serial clock, idles low |
| csN | input | 1 | Host chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| misoOe | output | 1 | Output enable for `miso`; low means high impedance |
| busy | output | 1 | Receive FIFO nearly full, with hysteresis |
| irq | output | 1 | Read data waiting for the host |
| rxData | output | 8 | Head of the receive FIFO |
| rxValid | output | 1 | Receive FIFO holds at least one byte |
| rxPop | input | 1 | Remove the head byte of the receive FIFO |
| txData | input | 8 | Byte to queue for the host |
| txPush | input | 1 | Queue `txData` in the transmit FIFO |
| txFull | output | 1 | Transmit FIFO cannot take another byte |

## Verification
The bench uses the default parameters: a 16-entry receive FIFO with release at four free entries, an 8-entry transmit FIFO and two synchronizer stages. With this size the receive FIFO can be filled to the brim inside one short run, so both hysteresis thresholds and the overflow drop are reached directly. All 128 header addresses are swept as writes, and a spread of addresses as reads, against a fixed device address. Expected bytes are computed with simple arithmetic from the loop index.

// File: rtl/spiSlvPkg.sv
package spiSlvPkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_WRITE,
    ST_READ,
    ST_MUTE
  } portState_t;

  // Strobes sent from control to datapath, one set per system clock
  typedef struct packed {
    logic dataBit;    // synchronized host data bit
    logic shiftIn;    // take dataBit into the input shifter
    logic pushRx;     // completed write byte ready
    logic loadTx;     // start of an outgoing byte (falling edge)
    logic shiftOut;   // next outgoing bit (falling edge)
    logic byteStart;  // first bit of an outgoing byte sampled by host
    logic csRise;     // deselect seen
    logic sclkFall;   // falling clock edge while selected
    logic idle;       // port deselected
    logic drive;      // drive the data output
  } spiStrobes_t;
endpackage

// File: rtl/spiByteFifo.sv
module spiByteFifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] wrData,
  input  logic             pop,
  output logic [WIDTH-1:0] rdData,
  output logic [CW-1:0]    count
);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic             pushOk, popOk;

  assign pushOk = push && (count != FULL_LVL);
  assign popOk  = pop && (count != '0);
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (popOk)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R10
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_LVL);
  // R10
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count == FULL_LVL && !pop) |=> count == FULL_LVL);
endmodule

// File: rtl/spiPortCtrl.sv
module spiPortCtrl
  import spiSlvPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkPin,
  input  logic              csNPin,
  input  logic              mosiPin,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic [BYTE_W-1:0] inByte,
  output spiStrobes_t       strobes
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] sclkPipe, csPipe, mosiPipe;
  logic sclkS, csS, mosiS, sclkPrev, csPrev;
  logic riseW, fallW, csRiseW, csFallW;
  portState_t state;
  logic [CNT_W-1:0] bitCnt;

  generate
    if (SYNC_STAGES > 1) begin : gMulti
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclkPipe <= '0;
          csPipe   <= '1;
          mosiPipe <= '0;
        end else begin
          sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclkPin};
          csPipe   <= {csPipe[SYNC_STAGES-2:0], csNPin};
          mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosiPin};
        end
      end
    end else begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclkPipe <= '0;
          csPipe   <= '1;
          mosiPipe <= '0;
        end else begin
          sclkPipe <= sclkPin;
          csPipe   <= csNPin;
          mosiPipe <= mosiPin;
        end
      end
    end
  endgenerate

  assign sclkS = sclkPipe[SYNC_STAGES-1];
  assign csS   = csPipe[SYNC_STAGES-1];
  assign mosiS = mosiPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkPrev <= sclkS;
      csPrev   <= csS;
    end
  end

  assign riseW   = sclkS && !sclkPrev;
  assign fallW   = !sclkS && sclkPrev;
  assign csRiseW = csS && !csPrev;
  assign csFallW = !csS && csPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (csS) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (csFallW) begin
      state  <= ST_HDR;
      bitCnt <= '0;
    end else if (riseW && (state == ST_HDR || state == ST_WRITE || state == ST_READ)) begin
      bitCnt <= bitCnt + 1'b1;
      if (state == ST_HDR && bitCnt == LAST_BIT) begin
        if (inByte[BYTE_W-1:1] != devAddr) state <= ST_MUTE;
        else if (inByte[0])                 state <= ST_READ;
        else                                state <= ST_WRITE;
      end
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.dataBit   = mosiS;
    strobes.shiftIn   = riseW && !csS && (state == ST_HDR || state == ST_WRITE);
    strobes.pushRx    = riseW && !csS && state == ST_WRITE && bitCnt == LAST_BIT;
    strobes.byteStart = riseW && !csS && state == ST_READ && bitCnt == '0;
    strobes.loadTx    = fallW && !csS && state == ST_READ && bitCnt == '0;
    strobes.shiftOut  = fallW && !csS && state == ST_READ && bitCnt != '0;
    strobes.csRise    = csRiseW;
    strobes.sclkFall  = fallW && !csS;
    strobes.idle      = csS;
    strobes.drive     = (state == ST_READ);
  end

  // R9
  partial_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    csRiseW |=> (bitCnt == '0 && state == ST_IDLE));
  // R3
  mute_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MUTE && !csS) |=> state == ST_MUTE);
endmodule

// File: rtl/spiPortDatapath.sv
module spiPortDatapath
  import spiSlvPkg::*;
#(
  parameter int RX_DEPTH      = 16,
  parameter int TX_DEPTH      = 8,
  parameter int BUSY_ON_FREE  = 1,
  parameter int BUSY_OFF_FREE = 4,
  localparam int RCW = $clog2(RX_DEPTH + 1),
  localparam int TCW = $clog2(TX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobes_t       strobes,
  output logic [BYTE_W-1:0] inByte,
  output logic              miso,
  output logic              misoOe,
  output logic              busy,
  output logic              irq,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxPop,
  input  logic [BYTE_W-1:0] txData,
  input  logic              txPush,
  output logic              txFull
);
  localparam logic [RCW-1:0] RX_FULL_LVL = RCW'(RX_DEPTH);
  localparam logic [RCW-1:0] BUSY_ON_LVL = RCW'(RX_DEPTH - BUSY_ON_FREE);
  localparam logic [RCW-1:0] BUSY_OFF_LVL = RCW'(RX_DEPTH - BUSY_OFF_FREE);
  localparam logic [TCW-1:0] TX_FULL_LVL = TCW'(TX_DEPTH);

  logic [BYTE_W-2:0] inShift;
  logic [BYTE_W-1:0] outShift, txHead, txByte;
  logic [RCW-1:0]    rxCount;
  logic [TCW-1:0]    txCount;
  logic rxPushOk, txPushOk, txEmpty, txPopW;
  logic misoReg, fromFifo, irqPending, irqApply;

  assign inByte   = {inShift, strobes.dataBit};
  assign rxPushOk = strobes.pushRx && (rxCount != RX_FULL_LVL);
  assign txFull   = (txCount == TX_FULL_LVL);
  assign txEmpty  = (txCount == '0);
  assign txPushOk = txPush && !txFull;
  assign txPopW   = strobes.byteStart && fromFifo;
  assign txByte   = txEmpty ? '0 : txHead;
  assign rxValid  = (rxCount != '0);

  spiByteFifo #(.DEPTH(RX_DEPTH), .WIDTH(BYTE_W)) rxFifo_i (
    .clk(clk), .rstN(rstN), .push(rxPushOk), .wrData(inByte),
    .pop(rxPop), .rdData(rxData), .count(rxCount));

  spiByteFifo #(.DEPTH(TX_DEPTH), .WIDTH(BYTE_W)) txFifo_i (
    .clk(clk), .rstN(rstN), .push(txPushOk), .wrData(txData),
    .pop(txPopW), .rdData(txHead), .count(txCount));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                inShift <= '0;
    else if (strobes.shiftIn) inShift <= inByte[BYTE_W-2:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      misoReg  <= 1'b0;
      outShift <= '0;
      fromFifo <= 1'b0;
    end else if (strobes.csRise) begin
      misoReg  <= 1'b0;
      outShift <= '0;
      fromFifo <= 1'b0;
    end else if (strobes.loadTx) begin
      misoReg  <= txByte[BYTE_W-1];
      outShift <= {txByte[BYTE_W-2:0], 1'b0};
      fromFifo <= !txEmpty;
    end else begin
      if (strobes.shiftOut) begin
        misoReg  <= outShift[BYTE_W-1];
        outShift <= {outShift[BYTE_W-2:0], 1'b0};
      end
      if (txPopW) fromFifo <= 1'b0;
    end
  end

  assign miso   = misoReg;
  assign misoOe = strobes.drive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        busy <= 1'b0;
    else if (rxCount >= BUSY_ON_LVL)  busy <= 1'b1;
    else if (rxCount <= BUSY_OFF_LVL) busy <= 1'b0;
  end

  assign irqApply = irqPending && !strobes.csRise && (strobes.sclkFall || strobes.idle);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPending <= 1'b0;
      irq        <= 1'b0;
    end else begin
      irqPending <= txPushOk || (irqPending && !irqApply);
      if (strobes.csRise) irq <= 1'b0;
      else if (irqApply)  irq <= 1'b1;
    end
  end

  // R7
  busy_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount >= BUSY_ON_LVL) |=> busy);
  // R7
  busy_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount <= BUSY_OFF_LVL) |=> !busy);
  // R8
  irq_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.csRise |=> !irq);
  // R6
  hiz_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.idle |=> !misoOe);
  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pushRx && rxCount == RX_FULL_LVL && !rxPop) |=> rxCount == RX_FULL_LVL);
endmodule

// File: rtl/hostSpiPort.sv
module hostSpiPort
  import spiSlvPkg::*;
#(
  parameter int RX_DEPTH      = 16,
  parameter int TX_DEPTH      = 8,
  parameter int BUSY_ON_FREE  = 1,
  parameter int BUSY_OFF_FREE = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [6:0]  devAddr,
  input  logic        sclk,
  input  logic        csN,
  input  logic        mosi,
  output logic        miso,
  output logic        misoOe,
  output logic        busy,
  output logic        irq,
  output logic [7:0]  rxData,
  output logic        rxValid,
  input  logic        rxPop,
  input  logic [7:0]  txData,
  input  logic        txPush,
  output logic        txFull
);
  spiStrobes_t       strobes;
  logic [BYTE_W-1:0] inByte;

  spiPortCtrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclkPin(sclk), .csNPin(csN), .mosiPin(mosi),
    .devAddr(devAddr), .inByte(inByte), .strobes(strobes));

  spiPortDatapath #(
    .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH),
    .BUSY_ON_FREE(BUSY_ON_FREE), .BUSY_OFF_FREE(BUSY_OFF_FREE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inByte(inByte),
    .miso(miso), .misoOe(misoOe), .busy(busy), .irq(irq),
    .rxData(rxData), .rxValid(rxValid), .rxPop(rxPop),
    .txData(txData), .txPush(txPush), .txFull(txFull));
endmodule

// File: tb/hostSpiPort_tb.sv
module hostSpiPort_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam logic [6:0] DEV = 7'h2D;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkDrv = 1'b0, csNDrv = 1'b1, mosiDrv = 1'b0;
  logic rxPop = 1'b0, txPush = 1'b0;
  logic [7:0] txData = '0;
  logic miso, misoOe, busy, irq, rxValid, txFull;
  logic [7:0] rxData;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit sawOe;
  logic [7:0] hostOut [32];
  logic [7:0] hostIn  [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  hostSpiPort dut_i (
    .clk(clk), .rstN(rstN), .devAddr(DEV), .sclk(sclkDrv), .csN(csNDrv),
    .mosi(mosiDrv), .miso(miso), .misoOe(misoOe), .busy(busy), .irq(irq),
    .rxData(rxData), .rxValid(rxValid), .rxPop(rxPop),
    .txData(txData), .txPush(txPush), .txFull(txFull));

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic v, output logic got);
    mosiDrv = v;
    waitClk(HALF);
    got = miso;
    if (misoOe) sawOe = 1;
    sclkDrv = 1'b1;
    waitClk(HALF);
    if (misoOe) sawOe = 1;
    sclkDrv = 1'b0;
  endtask

  // header, nBytes full data bytes, then tailBits bits of hostOut[nBytes+1]
  task automatic spiXfer(input logic [7:0] hdr, input int nBytes, input int tailBits);
    logic got;
    logic [7:0] acc;
    sawOe = 0;
    csNDrv = 1'b0;
    waitClk(HALF);
    for (int b = 0; b <= nBytes; b++) begin
      acc = '0;
      for (int i = 7; i >= 0; i--) begin
        sendBit((b == 0) ? hdr[i] : hostOut[b][i], got);
        acc = {acc[6:0], got};
      end
      hostIn[b] = acc;
    end
    for (int i = 0; i < tailBits; i++) sendBit(hostOut[nBytes+1][7-i], got);
    waitClk(HALF);
    csNDrv = 1'b1;
    waitClk(2*HALF);
  endtask

  task automatic popOne(output logic [7:0] v);
    v = rxData;
    rxPop = 1'b1;
    waitClk(1);
    rxPop = 1'b0;
    waitClk(1);
  endtask

  task automatic pushTx(input logic [7:0] v);
    txData = v;
    txPush = 1'b1;
    waitClk(1);
    txPush = 1'b0;
  endtask

  function automatic logic [7:0] fillVal(input int k);
    return 8'((k * 37 + 11) % 256);
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    logic got;
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);

    // R11 reset state
    check(!busy && !irq && !misoOe && !miso && !rxValid, "R11",
          {busy, irq, misoOe, miso, rxValid}, 0);

    // R1 R3 address sweep over all write headers
    for (int a = 0; a < 128; a++) begin
      hostOut[1] = 8'(a) ^ 8'h5A;
      spiXfer({7'(a), 1'b0}, 1, 0);
      if (7'(a) == DEV) begin
        check(rxValid && rxData == (8'(a) ^ 8'h5A), "R1", {7'd0, rxValid, rxData}, {8'd1, 8'(a) ^ 8'h5A});
        popOne(v);
      end else begin
        check(!rxValid && !sawOe, "R3", {rxValid, sawOe}, 0);
      end
    end

    // R3 R6 read headers to other addresses never enable the output
    for (int a = 1; a < 128; a += 8) begin
      spiXfer({7'(a), 1'b1}, 1, 0);
      check(!sawOe, "R3", sawOe, 0);
    end

    // R2 write burst
    hostOut[1] = 8'hA5; hostOut[2] = 8'h3C; hostOut[3] = 8'hFF; hostOut[4] = 8'h00;
    spiXfer({DEV, 1'b0}, 4, 0);
    for (int i = 1; i <= 4; i++) begin
      check(rxValid && rxData == hostOut[i], "R2", rxData, hostOut[i]);
      popOne(v);
    end
    check(!rxValid, "R2", rxValid, 0);

    // R8 attention raised by queued read data while idle
    pushTx(8'h81);
    pushTx(8'h7E);
    waitClk(4);
    check(irq == 1'b1, "R8", irq, 1);

    // R4 R6 single byte read, trailing edge must not lose the next byte
    spiXfer({DEV, 1'b1}, 1, 0);
    check(hostIn[1] == 8'h81, "R4", hostIn[1], 8'h81);
    check(sawOe == 1'b1, "R6", sawOe, 1);
    check(!misoOe, "R6", misoOe, 0);
    check(irq == 1'b0, "R8", irq, 0);

    // R4 R5 next read gets the second byte then zero fill
    spiXfer({DEV, 1'b1}, 2, 0);
    check(hostIn[1] == 8'h7E, "R4", hostIn[1], 8'h7E);
    check(hostIn[2] == 8'h00, "R5", hostIn[2], 0);

    // R9 partial data byte discarded
    hostOut[1] = 8'hC3; hostOut[2] = 8'h99;
    spiXfer({DEV, 1'b0}, 1, 5);
    check(rxValid && rxData == 8'hC3, "R9", rxData, 8'hC3);
    popOne(v);
    check(!rxValid, "R9", rxValid, 0);

    // R9 partial header then a clean write
    csNDrv = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < 3; i++) sendBit(1'b1, got);
    waitClk(HALF);
    csNDrv = 1'b1;
    waitClk(2*HALF);
    hostOut[1] = 8'h42;
    spiXfer({DEV, 1'b0}, 1, 0);
    check(rxValid && rxData == 8'h42, "R9", rxData, 8'h42);
    popOne(v);

    // R7 R10 fill, hysteresis and overflow
    for (int k = 0; k < 14; k++) hostOut[k+1] = fillVal(k);
    spiXfer({DEV, 1'b0}, 14, 0);
    check(busy == 1'b0, "R7", busy, 0);
    hostOut[1] = fillVal(14);
    spiXfer({DEV, 1'b0}, 1, 0);
    check(busy == 1'b1, "R7", busy, 1);
    hostOut[1] = fillVal(15); hostOut[2] = 8'hEE; hostOut[3] = 8'hEF;
    spiXfer({DEV, 1'b0}, 3, 0);
    check(busy == 1'b1, "R7", busy, 1);
    for (int k = 0; k < 3; k++) begin
      check(rxData == fillVal(k), "R10", rxData, fillVal(k));
      popOne(v);
    end
    waitClk(2);
    check(busy == 1'b1, "R7", busy, 1);
    check(rxData == fillVal(3), "R10", rxData, fillVal(3));
    popOne(v);
    waitClk(2);
    check(busy == 1'b0, "R7", busy, 0);
    for (int k = 4; k < 16; k++) begin
      check(rxValid && rxData == fillVal(k), "R10", rxData, fillVal(k));
      popOne(v);
    end
    check(!rxValid, "R10", rxValid, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule